// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block collects up to 32 raw interrupt inputs and folds them into a single request line toward a processor. Every input is brought into the local clock domain and judged either on a transition or on a level. The sense of each input (rising or high, against falling or low) is chosen per input. Each detected event is held in a pending register until software acknowledges it.

Software reaches seven 32-bit registers over a plain select/write/address/data bus. Reads are combinational. It can mask each pending bit away from the request line and acknowledge bits by writing ones. It can also raise pending bits by hand through an injection register. The request line can be driven as a level or as a single-cycle pulse, and it can be active high or active low. The reset choice is an active-low level.

Top module: `irq_gather`

## Requirements
- R1: Byte offsets on the bus are fixed: mask-enable 0x00, pending 0x04, input kind 0x08, input sense 0x0C, output kind 0x10, output sense 0x14, injection 0x18. Bit i of every per-input register belongs to input i. A written value reads back from 0x00, 0x08 and 0x0C in full, and from bit 0 of 0x10 and 0x14.
- R2: While reset is high, every register is cleared, the pending bits are zero and `irq_o` is held at 1, which is the inactive level of the default active-low output.
- R3: An input whose kind bit is 1 is edge sensitive. If its sense bit is 1, a rising transition sets its pending bit; if 0, a falling transition does. A transition of the other direction does nothing. The bit is set within three clock edges of the input change and then stays set.
- R4: A write to the pending register clears every bit written as 1 and leaves bits written as 0 unchanged. An event arriving in the same cycle wins over the clear.
- R5: An input whose kind bit is 0 is level sensitive. Its pending bit is set on every cycle its input is at the active level (high when the sense bit is 1, low when 0). A clear has no effect while that level lasts. Once the level is gone, the bit stays set until it is cleared.
- R6: The internal request is the OR over all inputs of pending AND mask-enable. A pending input whose enable bit is 0 leaves `irq_o` inactive.
- R7: Writing 1 to a bit of the injection register sets the matching pending bit in the same edge.
- R8: The injection register always reads as zero.
- R9: With output kind 0, `irq_o` is a registered level that follows the request one cycle later. It is low when active if the output sense bit is 0, and high when active if it is 1.
- R10: With output kind 1, `irq_o` is at the active level for exactly one cycle after each rising transition of the request, and inactive otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, used when bus_sel is high |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| src_i | input | N_SRC | Raw interrupt inputs, asynchronous |
| irq_o | output | 1 | Aggregated request line |

## Verification
Single inputs are toggled under every kind and sense pairing. Rising and falling edges show that only the selected direction sets a pending bit. A long level followed by a release shows that the level holds the bit through a clear, and that the bit then latches. A pending bit with its enable off tells masking apart from detection. Injected events driven through both output senses and both output kinds separate the level output from the single pulse. A behavioural model compares the request line on every cycle.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_MASK   = 5'h00,
        OFS_PEND   = 5'h04,
        OFS_KIND   = 5'h08,
        OFS_SENSE  = 5'h0C,
        OFS_OKIND  = 5'h10,
        OFS_OSENSE = 5'h14,
        OFS_INJECT = 5'h18
    } reg_ofs_e;

    typedef struct packed {
        logic pulse;   // 1: single-cycle pulse, 0: level
        logic high;    // 1: active high, 0: active low
    } out_cfg_t;

    function automatic logic bus_hit(input logic sel, input logic wr,
                                     input logic [ADDR_W-1:0] addr,
                                     input reg_ofs_e ofs);
        return sel && wr && (addr == ofs);
    endfunction

endpackage

// File: rtl/irqg_front.sv
module irqg_front #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] kind_i,
    input  logic [N_SRC-1:0] sense_i,
    output logic [N_SRC-1:0] edge_o,
    output logic [N_SRC-1:0] lvl_o
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic [1:0] sync_q;
        logic       prev_q;
        logic       cur;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[0], src_i[i]};
                prev_q <= sync_q[1];
            end
        end

        assign cur       = sync_q[1];
        assign edge_o[i] = kind_i[i] & (sense_i[i] ? (cur & ~prev_q) : (~cur & prev_q));
        assign lvl_o[i]  = ~kind_i[i] & ~(cur ^ sense_i[i]);
    end

endmodule

// File: rtl/irqg_outstage.sv
module irqg_outstage
    import irqg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_i,
    input  out_cfg_t cfg_i,
    output logic     irq_o
);

    logic req_d_q;
    logic out_q;
    logic active;

    assign active = cfg_i.pulse ? (req_i & ~req_d_q) : req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d_q <= 1'b0;
            out_q   <= 1'b1;
        end else begin
            req_d_q <= req_i;
            out_q   <= cfg_i.high ? active : ~active;
        end
    end

    assign irq_o = out_q;

    // R10: a pulse at the active level is followed by the inactive level
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.pulse && $stable(cfg_i) && !$past(rst) && irq_o == cfg_i.high)
        |=> (irq_o != cfg_i.high));

endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irqg_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [N_SRC-1:0]     src_i,
    output logic                 irq_o
);

    localparam int PAD_W = DATA_W - N_SRC;

    logic [N_SRC-1:0] mask_q, pend_q, kind_q, sense_q;
    out_cfg_t         ocfg_q;
    logic [N_SRC-1:0] edge_v, lvl_v, clr_v, inj_v, pend_d;
    logic             hit_pend, hit_inj, req;

    irqg_front #(.N_SRC(N_SRC)) u_front (
        .clk(clk), .rst(rst), .src_i(src_i),
        .kind_i(kind_q), .sense_i(sense_q),
        .edge_o(edge_v), .lvl_o(lvl_v)
    );

    assign hit_pend = bus_hit(bus_sel, bus_wr, bus_addr, OFS_PEND);
    assign hit_inj  = bus_hit(bus_sel, bus_wr, bus_addr, OFS_INJECT);

    always_comb begin
        clr_v  = hit_pend ? bus_wdata[N_SRC-1:0] : '0;
        inj_v  = hit_inj  ? bus_wdata[N_SRC-1:0] : '0;
        pend_d = (pend_q & ~clr_v) | edge_v | lvl_v | inj_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            pend_q  <= '0;
            kind_q  <= '0;
            sense_q <= '0;
            ocfg_q  <= '0;
        end else begin
            pend_q <= pend_d;
            if (bus_hit(bus_sel, bus_wr, bus_addr, OFS_MASK))   mask_q  <= bus_wdata[N_SRC-1:0];
            if (bus_hit(bus_sel, bus_wr, bus_addr, OFS_KIND))   kind_q  <= bus_wdata[N_SRC-1:0];
            if (bus_hit(bus_sel, bus_wr, bus_addr, OFS_SENSE))  sense_q <= bus_wdata[N_SRC-1:0];
            if (bus_hit(bus_sel, bus_wr, bus_addr, OFS_OKIND))  ocfg_q.pulse <= bus_wdata[0];
            if (bus_hit(bus_sel, bus_wr, bus_addr, OFS_OSENSE)) ocfg_q.high  <= bus_wdata[0];
        end
    end

    function automatic logic [DATA_W-1:0] widen(input logic [N_SRC-1:0] v);
        return {{PAD_W{1'b0}}, v};
    endfunction

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_MASK:   bus_rdata = widen(mask_q);
                OFS_PEND:   bus_rdata = widen(pend_q);
                OFS_KIND:   bus_rdata = widen(kind_q);
                OFS_SENSE:  bus_rdata = widen(sense_q);
                OFS_OKIND:  bus_rdata = {{(DATA_W-1){1'b0}}, ocfg_q.pulse};
                OFS_OSENSE: bus_rdata = {{(DATA_W-1){1'b0}}, ocfg_q.high};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign req = |(pend_q & mask_q);

    irqg_outstage u_out (
        .clk(clk), .rst(rst), .req_i(req), .cfg_i(ocfg_q), .irq_o(irq_o)
    );

    // R2: the cycle after reset everything is cleared and the line is inactive
    assert_reset_clear_R2: assert property (@(posedge clk)
        $past(rst) |-> (irq_o && pend_q == '0 && mask_q == '0));

    // R3: every edge seen by the front end is latched in the pending bits
    assert_edge_latched_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(edge_v) & ~pend_q) == '0));

    // R4: a written clear removes bits that had no new event in that cycle
    assert_clear_applies_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_pend)) |->
        ((pend_q & $past(bus_wdata[N_SRC-1:0] & ~(edge_v | lvl_v | inj_v))) == '0));

    // R5: an active level always leaves its pending bit set
    assert_level_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(lvl_v) & ~pend_q) == '0));

    // R7: injected bits show up as pending
    assert_inject_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_inj)) |->
        ((pend_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

    // R8: the injection register reads as zero
    assert_inject_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr == OFS_INJECT) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_irq_gather.sv
module sim_irq_gather;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] src = '0;
    logic        irq_o;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_gather #(.N_SRC(N)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_i(src), .irq_o(irq_o)
    );

    // behavioural reference model
    logic [N-1:0] m_en, m_st, m_kind, m_sense, h1, h2, h3;
    logic m_om, m_op, m_out, m_rd;

    always @(posedge clk) begin
        logic [N-1:0] ev, lv, clr, frc;
        logic req, act;
        if (rst) begin
            m_en = '0; m_st = '0; m_kind = '0; m_sense = '0;
            h1 = '0; h2 = '0; h3 = '0;
            m_om = 0; m_op = 0; m_out = 1; m_rd = 0;
        end else begin
            ev = '0; lv = '0;
            for (int i = 0; i < N; i++) begin
                if (m_kind[i]) ev[i] = m_sense[i] ? (h2[i] && !h3[i]) : (!h2[i] && h3[i]);
                else           lv[i] = (h2[i] == m_sense[i]);
            end
            clr = (bus_sel && bus_wr && bus_addr == 5'h04) ? bus_wdata : '0;
            frc = (bus_sel && bus_wr && bus_addr == 5'h18) ? bus_wdata : '0;
            req = |(m_st & m_en);
            act = m_om ? (req && !m_rd) : req;
            m_out = m_op ? act : !act;
            m_rd = req;
            m_st = (m_st & ~clr) | ev | lv | frc;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    5'h00: m_en = bus_wdata;
                    5'h08: m_kind = bus_wdata;
                    5'h0C: m_sense = bus_wdata;
                    5'h10: m_om = bus_wdata[0];
                    5'h14: m_op = bus_wdata[0];
                    default: ;
                endcase
            end
            h3 = h2; h2 = h1; h1 = src;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of the request line (R6 R9 R10)
    always @(negedge clk) begin
        if (!rst && !done) chk("R6 R9 R10 line vs model", {31'b0, irq_o}, {31'b0, m_out});
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        bus_sel = 1; bus_addr = 5'h04;
        rst = 0;
        #1;
        chk("R2 pending after reset", bus_rdata, 32'h0);
        chk("R2 line inactive after reset", {31'b0, irq_o}, 32'h1);
        bus_sel = 0;
        rd(5'h00, 32'h0, "R2 mask after reset");

        // all inputs edge, rising
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h08, 32'hFFFF_FFFF, "R1 kind readback");
        rd(5'h0C, 32'hFFFF_FFFF, "R1 sense readback");
        rd(5'h04, 32'h0, "R4 clear all");
        wr(5'h00, 32'h0000_00FF);
        rd(5'h00, 32'h0000_00FF, "R1 mask readback");

        // rising edge on input 3
        @(negedge clk); src[3] = 1;
        idle(4);
        rd(5'h04, 32'h0000_0008, "R3 rising edge latched");
        chk("R9 active-low asserted", {31'b0, irq_o}, 32'h0);
        wr(5'h04, 32'h0);
        rd(5'h04, 32'h0000_0008, "R4 zero write keeps bit");
        wr(5'h04, 32'h0000_0008);
        rd(5'h04, 32'h0, "R4 one write clears");
        idle(2);
        chk("R9 line released", {31'b0, irq_o}, 32'h1);

        // falling-edge input 5
        wr(5'h0C, 32'hFFFF_FFDF);
        @(negedge clk); src[5] = 1;
        idle(4);
        rd(5'h04, 32'h0, "R3 rising ignored on falling input");
        @(negedge clk); src[5] = 0;
        idle(4);
        rd(5'h04, 32'h0000_0020, "R3 falling edge latched");
        wr(5'h04, 32'hFFFF_FFFF);

        // masked input 20
        @(negedge clk); src[20] = 1;
        idle(4);
        rd(5'h04, 32'h0010_0000, "R6 masked input pending");
        chk("R6 masked input leaves line idle", {31'b0, irq_o}, 32'h1);
        wr(5'h04, 32'hFFFF_FFFF);

        // level, active-high on input 1
        wr(5'h08, 32'hFFFF_FFFD);
        @(negedge clk); src[1] = 1;
        idle(4);
        rd(5'h04, 32'h0000_0002, "R5 level sets pending");
        wr(5'h04, 32'h0000_0002);
        rd(5'h04, 32'h0000_0002, "R5 clear blocked by level");
        @(negedge clk); src[1] = 0;
        idle(4);
        rd(5'h04, 32'h0000_0002, "R5 bit latched after release");
        wr(5'h04, 32'h0000_0002);
        rd(5'h04, 32'h0, "R5 clear after release");

        // injection
        wr(5'h18, 32'h8000_0001);
        rd(5'h04, 32'h8000_0001, "R7 injection sets pending");
        rd(5'h18, 32'h0, "R8 injection reads zero");

        // output sense high
        wr(5'h14, 32'h1);
        rd(5'h14, 32'h1, "R1 output sense readback");
        idle(2);
        chk("R9 active-high asserted", {31'b0, irq_o}, 32'h1);
        wr(5'h14, 32'h0);
        idle(2);
        chk("R9 active-low asserted again", {31'b0, irq_o}, 32'h0);

        // pulse output, active high
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h14, 32'h1);
        wr(5'h10, 32'h1);
        rd(5'h10, 32'h1, "R1 output kind readback");
        idle(3);
        begin
            int hits = 0;
            wr(5'h18, 32'h0000_0004);
            for (int k = 0; k < 6; k++) begin
                if (irq_o) hits++;
                @(negedge clk);
            end
            chk("R10 one pulse per request rise", hits, 1);
        end
        rd(5'h04, 32'h0000_0004, "R10 pending held under pulse mode");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule